// File: doc/BRIEF.md
# Unrolled AES-128 Encryption Pipeline

This block encrypts 128-bit blocks under AES-128 at a rate of one block per clock. Each of the eleven key-dependent steps has its own hardware: one stage for the key whitening, nine standard rounds, and one final round. Each step ends in a register. A block presented with `in_valid` high leaves the block, encrypted, a fixed eleven clocks later with `out_valid` high. Any pattern of valid and idle cycles passes through the pipeline unchanged.

The block does not expand the key. The eleven round keys are computed elsewhere and written into a local store through a simple indexed write port, one 128-bit key per write. Each stage reads its own key directly from that store. The store is meant to be loaded while the pipeline is empty. It keeps its contents through reset, so one key load can serve any number of blocks.

Bytes are numbered from the most significant end: `in_data[127:120]` is byte 0. Byte k sits in row k mod 4 and column k div 4 of the 4x4 state, so the state is filled column by column.

Top module: `aes128_pipe_enc`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 11 rising clock edges. A new block is accepted on every cycle.
- R2: When `out_valid` is high, `out_data` is the AES-128 encryption of the matching input block under round keys 0 to 10 in the store. Byte 0 is `in_data[127:120]`, and byte k maps to state row k mod 4, column k div 4. The steps are key whitening with key 0, then nine rounds of S-box substitution, row rotation (row r rotated left by r bytes), column mixing and key addition, then a final round without column mixing.
- R3: Plaintext 00112233445566778899aabbccddeeff under the schedule expanded from key 000102030405060708090a0b0c0d0e0f encrypts to 69c4e0d86a7b0430d8cdb78070b4c55a. Plaintext 3243f6a8885a308d313198a2e0370734 under the schedule of key 2b7e151628aed2a6abf7158809cf4f3c encrypts to 3925841d02dc09fbdc118597196a0b32.
- R4: A write with `key_wr_en` high and `key_wr_idx` between 0 and 10 replaces round key `key_wr_idx` at the next edge. A write with an index from 11 to 15 changes no stored key.
- R5: A synchronous reset clears every valid bit in the pipeline. After reset is released, `out_valid` stays low until a block entered after reset reaches the end.
- R6: Idle input cycles (`in_valid` low) appear as idle output cycles exactly 11 clocks later, in between the surrounding blocks.
- R7: Reset leaves the stored round keys unchanged. Blocks encrypted after a reset use the keys loaded before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears only the valid bits |
| in_valid | input | 1 | Marks `in_data` as a block to encrypt |
| in_data | input | 128 | Plaintext block, byte 0 in bits 127:120 |
| key_wr_en | input | 1 | Writes one round key into the store |
| key_wr_idx | input | 4 | Round key number, 0 to 10; 11 to 15 are ignored |
| key_wr_data | input | 128 | Round key value, same byte order as the data |
| out_valid | output | 1 | Marks `out_data` as a finished ciphertext |
| out_data | output | 128 | Ciphertext block |

## Verification
A fault in the substitution, row rotation, column mixing or key addition of any one stage spreads across the whole block within the remaining rounds. It shows up as a wrong `out_data` on the first valid output, eleven clocks after the first affected block enters. A valid bit that is lost, duplicated or left set by reset shows up immediately as `out_valid` differing from the input pattern shifted by eleven cycles. Comparing both outputs every clock against a behavioural model catches either fault on the cycle it reaches the ports. A key written to the wrong slot, or a write with an out-of-range index that is not ignored, corrupts the next ciphertext produced with the affected key.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

  localparam int BLK_W    = 128;
  localparam int BLK_BYTES = BLK_W / 8;

  typedef logic [BLK_W-1:0] blk_t;
  typedef logic [7:0]       gf_t;

  localparam int MODE_WHITEN = 0;
  localparam int MODE_ROUND  = 1;
  localparam int MODE_LAST   = 2;

  function automatic gf_t byte_at(blk_t v, int k);
    return v[BLK_W-1-8*k -: 8];
  endfunction

  function automatic gf_t gf_dbl(gf_t a);
    return a[7] ? ({a[6:0], 1'b0} ^ 8'h1b) : {a[6:0], 1'b0};
  endfunction

  function automatic gf_t gf_tpl(gf_t a);
    return gf_dbl(a) ^ a;
  endfunction

  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t acc;
    gf_t run;
    acc = '0;
    run = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ run;
      run = gf_dbl(run);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (a^2 * a^4 * ... * a^128); 0 maps to 0
  function automatic gf_t gf_inv(gf_t a);
    gf_t sq;
    gf_t prod;
    sq   = gf_mul(a, a);
    prod = sq;
    for (int i = 0; i < 6; i++) begin
      sq   = gf_mul(sq, sq);
      prod = gf_mul(prod, sq);
    end
    return prod;
  endfunction

  function automatic gf_t rotl8(gf_t v, int n);
    gf_t r;
    r = v;
    for (int i = 0; i < n; i++) r = {r[6:0], r[7]};
    return r;
  endfunction

  function automatic gf_t sbox(gf_t a);
    gf_t b;
    b = gf_inv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic blk_t sub_bytes(blk_t v);
    blk_t r;
    for (int k = 0; k < BLK_BYTES; k++)
      r[BLK_W-1-8*k -: 8] = sbox(byte_at(v, k));
    return r;
  endfunction

  // byte k holds row k%4, column k/4; row r takes its byte from column (c+r)%4
  function automatic blk_t shift_rows(blk_t v);
    blk_t r;
    for (int c = 0; c < 4; c++)
      for (int row = 0; row < 4; row++)
        r[BLK_W-1-8*(4*c+row) -: 8] = byte_at(v, 4*((c+row)%4) + row);
    return r;
  endfunction

  function automatic blk_t mix_columns(blk_t v);
    blk_t r;
    gf_t a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = byte_at(v, 4*c);
      a1 = byte_at(v, 4*c+1);
      a2 = byte_at(v, 4*c+2);
      a3 = byte_at(v, 4*c+3);
      r[BLK_W-1-8*(4*c)   -: 8] = gf_dbl(a0) ^ gf_tpl(a1) ^ a2 ^ a3;
      r[BLK_W-1-8*(4*c+1) -: 8] = a0 ^ gf_dbl(a1) ^ gf_tpl(a2) ^ a3;
      r[BLK_W-1-8*(4*c+2) -: 8] = a0 ^ a1 ^ gf_dbl(a2) ^ gf_tpl(a3);
      r[BLK_W-1-8*(4*c+3) -: 8] = gf_tpl(a0) ^ a1 ^ a2 ^ gf_dbl(a3);
    end
    return r;
  endfunction

endpackage

// File: rtl/aes_key_store.sv
module aes_key_store #(
  parameter int NKEYS = 11,
  parameter int W     = 128,
  parameter int IDXW  = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [W-1:0]      wr_data,
  output logic [NKEYS*W-1:0] rk_flat
);

  // one register per round key; no reset so loaded keys survive reset
  for (genvar k = 0; k < NKEYS; k++) begin : g_slot
    logic [W-1:0] slot_q;
    logic         slot_hit;
    assign slot_hit = wr_en && (wr_idx == IDXW'(k));
    always_ff @(posedge clk) begin
      if (slot_hit) slot_q <= wr_data;
    end
    assign rk_flat[k*W +: W] = slot_q;
  end

endmodule

// File: rtl/aes_round_stage.sv
module aes_round_stage
  import aes_enc_pkg::*;
#(
  parameter int MODE = MODE_ROUND
) (
  input  logic clk,
  input  logic rst,
  input  logic v_in,
  input  blk_t d_in,
  input  blk_t rk,
  output logic v_out,
  output blk_t d_out
);

  blk_t sb_out;
  blk_t sr_out;
  blk_t mc_out;
  blk_t nxt;

  if (MODE == MODE_WHITEN) begin : g_whiten
    assign sb_out = d_in;
    assign sr_out = d_in;
    assign mc_out = d_in;
  end else if (MODE == MODE_ROUND) begin : g_round
    assign sb_out = sub_bytes(d_in);
    assign sr_out = shift_rows(sb_out);
    assign mc_out = mix_columns(sr_out);
  end else begin : g_last
    assign sb_out = sub_bytes(d_in);
    assign sr_out = shift_rows(sb_out);
    assign mc_out = sr_out;
  end

  assign nxt = mc_out ^ rk;

  always_ff @(posedge clk) begin
    if (rst) v_out <= 1'b0;
    else     v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    d_out <= nxt;
  end

endmodule

// File: rtl/aes128_pipe_enc.sv
module aes128_pipe_enc
  import aes_enc_pkg::*;
#(
  parameter int NR = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [127:0] in_data,
  input  logic         key_wr_en,
  input  logic [3:0]   key_wr_idx,
  input  logic [127:0] key_wr_data,
  output logic         out_valid,
  output logic [127:0] out_data
);

  localparam int LAT   = NR + 1;
  localparam int NKEYS = NR + 1;

  logic [NKEYS*BLK_W-1:0] rk_flat;
  logic [LAT:0]           v_chain;
  blk_t                   d_chain [LAT+1];
  logic [LAT-1:0]         stage_v;

  aes_key_store #(
    .NKEYS (NKEYS),
    .W     (BLK_W),
    .IDXW  (4)
  ) u_keys (
    .clk     (clk),
    .wr_en   (key_wr_en),
    .wr_idx  (key_wr_idx),
    .wr_data (key_wr_data),
    .rk_flat (rk_flat)
  );

  assign v_chain[0] = in_valid;
  assign d_chain[0] = in_data;

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    localparam int KIND = (s == 0)  ? MODE_WHITEN :
                          (s == NR) ? MODE_LAST   : MODE_ROUND;
    aes_round_stage #(.MODE(KIND)) u_stage (
      .clk   (clk),
      .rst   (rst),
      .v_in  (v_chain[s]),
      .d_in  (d_chain[s]),
      .rk    (rk_flat[s*BLK_W +: BLK_W]),
      .v_out (v_chain[s+1]),
      .d_out (d_chain[s+1])
    );
  end

  assign stage_v   = v_chain[LAT:1];
  assign out_valid = v_chain[LAT];
  assign out_data  = d_chain[LAT];

endmodule

// File: rtl/aes128_pipe_enc_chk.sv
module aes128_pipe_enc_chk #(
  parameter int NR = 10
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  out_valid,
  input logic                  key_wr_en,
  input logic [3:0]            key_wr_idx,
  input logic [127:0]          key_wr_data,
  input logic [NR:0]           stage_v,
  input logic [(NR+1)*128-1:0] rk_flat
);

  localparam int LAT   = NR + 1;
  localparam int NKEYS = NR + 1;

  logic       armed;
  logic [4:0] age;
  logic [3:0] last_idx;
  logic [127:0] sel_key;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      age   <= '0;
    end else begin
      armed <= 1'b1;
      if (age != 5'(LAT)) age <= age + 5'd1;
    end
  end

  always_ff @(posedge clk) last_idx <= key_wr_idx;

  always_comb begin
    sel_key = '0;
    for (int k = 0; k < NKEYS; k++)
      if (last_idx == 4'(k)) sel_key = rk_flat[k*128 +: 128];
  end

  // R1: each valid bit moves one stage per clock
  a_r1_stage_shift: assert property (@(posedge clk) disable iff (rst)
    armed |-> stage_v == $past({stage_v[LAT-2:0], in_valid}));

  // R1, R6: output valid is the input valid eleven edges earlier
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    (age == 5'(LAT)) |-> out_valid == $past(in_valid, 11));

  // R5: reset leaves no valid bit behind
  a_r5_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stage_v == '0 && !out_valid));

  // R4: in-range write lands in the addressed slot
  a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
    (key_wr_en && key_wr_idx <= 4'(NKEYS-1)) |=> sel_key == $past(key_wr_data));

  // R4: out-of-range index changes nothing
  a_r4_ignore_high: assert property (@(posedge clk) disable iff (rst)
    (key_wr_en && key_wr_idx > 4'(NKEYS-1)) |=> $stable(rk_flat));

endmodule

bind aes128_pipe_enc aes128_pipe_enc_chk #(.NR(NR)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .key_wr_en   (key_wr_en),
  .key_wr_idx  (key_wr_idx),
  .key_wr_data (key_wr_data),
  .stage_v     (stage_v),
  .rk_flat     (rk_flat)
);

// File: tb/aes128_pipe_enc_tb_top.sv
module aes128_pipe_enc_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_data = '0;
  logic         key_wr_en = 1'b0;
  logic [3:0]   key_wr_idx = '0;
  logic [127:0] key_wr_data = '0;
  logic         out_valid;
  logic [127:0] out_data;

  int nchk = 0;
  int nfail = 0;
  bit cmp_en = 0;
  bit done = 0;

  always #10 clk = ~clk;

  aes128_pipe_enc dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .key_wr_en(key_wr_en), .key_wr_idx(key_wr_idx), .key_wr_data(key_wr_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  // ---------------- reference model ----------------
  logic [7:0]   sb [256];
  logic [127:0] bk [11];

  function automatic logic [7:0] xt(logic [7:0] a);
    return (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  task automatic build_sbox();
    int lg [256];
    logic [7:0] ex [256];
    logic [7:0] t, inv, s;
    t = 8'h01;
    for (int i = 0; i < 255; i++) begin
      ex[i] = t;
      lg[t] = i;
      t = t ^ xt(t);
    end
    for (int x = 0; x < 256; x++) begin
      inv = (x == 0) ? 8'h00 : ex[(255 - lg[x]) % 255];
      s = 8'h63;
      for (int r = 0; r < 5; r++) s = s ^ ((inv << r) | (inv >> (8 - r)));
      sb[x] = s;
    end
  endtask

  function automatic logic [127:0] ref_enc(logic [127:0] pt);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] a0, a1, a2, a3;
    for (int k = 0; k < 16; k++) s[k] = pt[127-8*k -: 8] ^ bk[0][127-8*k -: 8];
    for (int rnd = 1; rnd <= 10; rnd++) begin
      for (int k = 0; k < 16; k++) s[k] = sb[s[k]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) t[4*c+r] = s[4*((c+r)%4)+r];
      if (rnd != 10) begin
        for (int c = 0; c < 4; c++) begin
          a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
          t[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
          t[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
          t[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
          t[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        end
      end
      for (int k = 0; k < 16; k++) s[k] = t[k] ^ bk[rnd][127-8*k -: 8];
    end
    for (int k = 0; k < 16; k++) ref_enc[127-8*k -: 8] = s[k];
  endfunction

  function automatic logic [127:0] round_key(logic [127:0] key, int idx);
    logic [31:0] w [44];
    logic [31:0] tmp;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      tmp = w[i-1];
      if (i % 4 == 0) begin
        tmp = {tmp[23:0], tmp[31:24]};
        tmp = {sb[tmp[31:24]], sb[tmp[23:16]], sb[tmp[15:8]], sb[tmp[7:0]]} ^ {rc, 24'h0};
        rc = xt(rc);
      end
      w[i] = w[i-4] ^ tmp;
    end
    return {w[4*idx], w[4*idx+1], w[4*idx+2], w[4*idx+3]};
  endfunction

  logic         mv [11];
  logic [127:0] md [11];

  always @(posedge clk) begin
    mv[0] <= rst ? 1'b0 : in_valid;
    md[0] <= ref_enc(in_data);
    for (int i = 1; i < 11; i++) begin
      mv[i] <= rst ? 1'b0 : mv[i-1];
      md[i] <= md[i-1];
    end
    if (key_wr_en && key_wr_idx <= 4'd10) bk[key_wr_idx] <= key_wr_data;
  end

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R1, R2, R6)
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(out_valid === mv[10], "R1/R6 valid", {127'b0, out_valid}, {127'b0, mv[10]});
      if (mv[10]) chk(out_data === md[10], "R2 data", out_data, md[10]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic load_key(logic [127:0] key);
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      key_wr_en = 1'b1; key_wr_idx = 4'(i); key_wr_data = round_key(key, i);
    end
    @(negedge clk);
    key_wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    in_valid = 1'b0;
  endtask

  // single block with an exact-cycle check of the known answer
  task automatic one_block(logic [127:0] pt, logic [127:0] ct, string req);
    @(negedge clk);
    in_valid = 1'b1; in_data = pt;
    @(negedge clk);
    in_valid = 1'b0; in_data = '0;
    repeat (9) @(negedge clk);
    chk(out_valid === 1'b0, "R1 early", {127'b0, out_valid}, 128'd0);
    @(negedge clk);
    chk(out_valid === 1'b1, "R1 on time", {127'b0, out_valid}, 128'd1);
    chk(out_data === ct, req, out_data, ct);
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 single", {127'b0, out_valid}, 128'd0);
  endtask

  localparam logic [127:0] KEY_A = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] PT_A  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] CT_A  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] KEY_B = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] PT_B  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] CT_B  = 128'h3925841d02dc09fbdc118597196a0b32;

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    build_sbox();
    for (int i = 0; i < 11; i++) bk[i] = '0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R5 reset state", {127'b0, out_valid}, 128'd0);
    rst = 1'b0;
    cmp_en = 1;

    load_key(KEY_A);                                   // R4 in-range writes
    one_block(PT_A, CT_A, "R3 vector A");

    // back-to-back stream with bubbles: R1, R2, R6
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      in_valid = (i % 5 != 3) && (i % 7 != 6);
      in_data  = {$urandom, $urandom, $urandom, $urandom};
    end
    idle(14);

    // R4: out-of-range indices must not disturb the store
    @(negedge clk);
    key_wr_en = 1'b1; key_wr_idx = 4'd11; key_wr_data = '1;
    @(negedge clk);
    key_wr_idx = 4'd15; key_wr_data = 128'hdeadbeef;
    @(negedge clk);
    key_wr_en = 1'b0;
    one_block(PT_A, CT_A, "R4 ignored write");

    // R5: reset mid-stream discards all blocks in flight
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = {$urandom, $urandom, $urandom, $urandom};
    end
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 12; i++) begin
      chk(out_valid === 1'b0, "R5 flushed", {127'b0, out_valid}, 128'd0);
      @(negedge clk);
    end

    // R7: keys survive reset
    one_block(PT_A, CT_A, "R7 keys kept");

    // second key set and stream
    idle(2);
    load_key(KEY_B);
    one_block(PT_B, CT_B, "R3 vector B");
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      in_valid = (i % 4 != 2);
      in_data  = {$urandom, $urandom, $urandom, $urandom};
    end
    idle(14);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

endmodule